// File: doc/BRIEF.md
# Multi-Channel Divider Synchronization Controller

This block holds a bank of programmable output clock dividers and releases them together on one synchronization event. The event comes either from a direct request strobe or from an edge detector. The detector must be armed first. It then watches a selectable edge input, either the loop feedback edge or the active reference edge, and fires once on the next rising edge it sees.

Each channel has a mask bit. Unmasked channels freeze and hold their output while they wait for the event. When the event arrives, every unmasked divider restarts from count zero, output low, on the same input clock edge, so the whole set ends up phase-aligned. Masked channels keep dividing and do not react to the event. A status pulse marks the release and a busy flag shows that some unmasked channel is waiting. The alignment happens once per event and does not follow later drift.

Top module: `divsync_ctrl`

## Requirements
- R1: After reset every divided clock output is low, the sync pulse is low, the detector is disarmed, and every channel is stalled, so busy is high while any mask bit is clear.
- R2: A channel whose mask bit is 1 keeps dividing from reset onward, with its count advancing every cycle, and is not restarted by a release.
- R3: A stalled unmasked channel holds its count and its output steady until a release.
- R4: Source select 0 takes the direct request as the trigger and ignores the edge inputs. Source select 1 uses the armed edge detector and ignores the direct request.
- R5: In edge mode, edge select 0 watches the feedback edge input and edge select 1 watches the reference edge input. Rising edges on the other input are ignored.
- R6: The detector fires only when armed. An unarmed edge, or an arm strobe while source select is 0, has no effect.
- R7: After firing, the detector disarms itself. A further edge produces no event until it is armed again.
- R8: Take E as the clock edge that samples the trigger. Every unmasked channel restarts at edge E+4 with count 0 and output low. For a ratio Q of 2 or more, its first period therefore ends with a falling output edge at edge E+4+Q, Q+4 cycles after the event.
- R9: The sync pulse output is high for exactly one cycle, in the cycle that follows release edge E+4.
- R10: Busy is high exactly while some unmasked channel is stalled. A trigger stalls the unmasked channels at edge E+1. An accepted arm strobe (sampled at edge A) stalls them at edge A+1, and the edge that fires later releases them.
- R11: A ratio of 1, or of 0, passes the input clock straight to the output, gated low while the channel is stalled.
- R12: While a release is pending (edges E+1 to E+4), further triggers and arm strobes are ignored.
- R13: For a ratio Q of 2 or more, a running channel's count cycles from 0 to Q-1. The output is high while the count is at least floor(Q/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock that all dividers count |
| rst_i | input | 1 | Synchronous active-high reset |
| src_sel_i | input | 1 | Trigger source: 0 direct request, 1 armed edge detector |
| edge_sel_i | input | 1 | Edge watched in edge mode: 0 feedback, 1 reference |
| arm_i | input | 1 | Arm strobe for the edge detector |
| dsync_i | input | 1 | Direct synchronization request |
| fb_edge_i | input | 1 | Loop feedback edge input |
| ref_edge_i | input | 1 | Active reference edge input |
| ratio_i | input | NCH*QW | Divide ratios, channel n in bits [n*QW +: QW] |
| mask_i | input | NCH | Per-channel mask; 1 lets the channel run through a sync |
| div_clk_o | output | NCH | Divided clock outputs |
| sync_pulse_o | output | 1 | One-cycle pulse on release |
| busy_o | output | 1 | High while any unmasked channel is stalled |

## Verification
The assertions assume that the mask bits stay steady from a trigger through its release edge. If a mask bit dropped while its stalled channel sat frozen, busy could stay high after a release, and the frozen-channel property would be checked against a mask that had changed under it. The stimulus sets the masks once during reset and never touches them again. It changes a divide ratio only on a channel the scoreboard no longer scores, and only outside a pending release. All request, arm and edge inputs change at the falling clock edge, so each one is sampled at a single, known rising edge.

// File: rtl/divsync_pkg.sv
`timescale 1ns/1ps
package divsync_pkg;

  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_EDGE   = 1'b1
  } src_sel_e;

  typedef enum logic {
    EDGE_FEEDBACK  = 1'b0,
    EDGE_REFERENCE = 1'b1
  } edge_sel_e;

endpackage

// File: rtl/divsync_trigger.sv
`timescale 1ns/1ps
module divsync_trigger
  import divsync_pkg::*;
#(
  parameter int REL_DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic src_sel_i,
  input  logic edge_sel_i,
  input  logic arm_i,
  input  logic dsync_i,
  input  logic fb_edge_i,
  input  logic ref_edge_i,
  output logic stall_go_o,
  output logic release_o
);

  logic                 fb_d, ref_d;
  logic                 armed_q, evt_q, arm_q;
  logic [REL_DEPTH-1:0] pipe_q;
  logic                 pending, auto_mode, edge_hit, fire, arm_take;

  assign auto_mode = (src_sel_e'(src_sel_i) == SRC_EDGE);
  assign pending   = evt_q | (|pipe_q);
  assign edge_hit  = (edge_sel_e'(edge_sel_i) == EDGE_REFERENCE) ? (ref_edge_i & ~ref_d)
                                                                 : (fb_edge_i & ~fb_d);
  assign fire      = !pending && (auto_mode ? (armed_q && edge_hit) : dsync_i);
  assign arm_take  = auto_mode && arm_i && !armed_q && !pending;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fb_d    <= 1'b0;
      ref_d   <= 1'b0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      fb_d  <= fb_edge_i;
      ref_d <= ref_edge_i;
      evt_q <= fire;
      arm_q <= arm_take;
      if (!auto_mode || fire) armed_q <= 1'b0;
      else if (arm_take)      armed_q <= 1'b1;
    end
  end

  generate
    if (REL_DEPTH == 1) begin : g_pipe_one
      always_ff @(posedge clk_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= evt_q;
      end
    end else begin : g_pipe_multi
      always_ff @(posedge clk_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= {pipe_q[REL_DEPTH-2:0], evt_q};
      end
    end
  endgenerate

  assign stall_go_o = evt_q | arm_q;
  assign release_o  = pipe_q[REL_DEPTH-1];

  // R7
  disarm_after_fire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire && auto_mode) |=> !armed_q);

  // R6
  unarmed_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (auto_mode && !armed_q) |=> !evt_q);

  // R12
  single_event_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_q |=> !evt_q);

endmodule

// File: rtl/divsync_divider.sv
`timescale 1ns/1ps
module divsync_divider #(
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [QW-1:0] ratio_i,
  input  logic          mask_i,
  input  logic          stall_go_i,
  input  logic          release_i,
  output logic          div_clk_o,
  output logic          stalled_o
);

  localparam logic [QW-1:0] ONE = QW'(1);

  logic [QW-1:0] cnt_q, cnt_nx;
  logic          out_q, out_nx, hold_q;
  logic          pass, freeze, rel_me;

  assign pass   = (ratio_i <= ONE);
  assign freeze = hold_q & ~mask_i;
  assign rel_me = release_i & ~mask_i;

  always_comb begin
    if (pass || cnt_q >= ratio_i - ONE) cnt_nx = '0;
    else                                cnt_nx = cnt_q + ONE;
    out_nx = !pass && (cnt_nx >= (ratio_i >> 1));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      hold_q <= 1'b1;
    end else if (rel_me) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (stall_go_i && !mask_i) hold_q <= 1'b1;
      if (!freeze) begin
        cnt_q <= cnt_nx;
        out_q <= out_nx;
      end
    end
  end

  assign div_clk_o = pass ? (clk_i & ~freeze) : out_q;
  assign stalled_o = freeze;

  // R3
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (freeze && !release_i) |=> ($stable(cnt_q) && $stable(out_q)));

  // R8
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (release_i && !mask_i) |=> (cnt_q == '0 && !out_q));

  // R2
  masked_runs_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mask_i && ratio_i >= QW'(2)) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/divsync_ctrl.sv
`timescale 1ns/1ps
module divsync_ctrl #(
  parameter int NCH       = 4,
  parameter int QW        = 8,
  parameter int REL_DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              src_sel_i,
  input  logic              edge_sel_i,
  input  logic              arm_i,
  input  logic              dsync_i,
  input  logic              fb_edge_i,
  input  logic              ref_edge_i,
  input  logic [NCH*QW-1:0] ratio_i,
  input  logic [NCH-1:0]    mask_i,
  output logic [NCH-1:0]    div_clk_o,
  output logic              sync_pulse_o,
  output logic              busy_o
);

  logic           stall_go, release_w, sync_pulse_q;
  logic [NCH-1:0] stalled_w;

  divsync_trigger #(.REL_DEPTH(REL_DEPTH)) u_trig (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .src_sel_i  (src_sel_i),
    .edge_sel_i (edge_sel_i),
    .arm_i      (arm_i),
    .dsync_i    (dsync_i),
    .fb_edge_i  (fb_edge_i),
    .ref_edge_i (ref_edge_i),
    .stall_go_o (stall_go),
    .release_o  (release_w)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      divsync_divider #(.QW(QW)) u_div (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ratio_i    (ratio_i[g*QW +: QW]),
        .mask_i     (mask_i[g]),
        .stall_go_i (stall_go),
        .release_i  (release_w),
        .div_clk_o  (div_clk_o[g]),
        .stalled_o  (stalled_w[g])
      );
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_pulse_q <= 1'b0;
    else       sync_pulse_q <= release_w;
  end

  assign sync_pulse_o = sync_pulse_q;
  assign busy_o       = |stalled_w;

  // R9
  sync_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_pulse_o |=> !sync_pulse_o);

  // R10
  busy_clear_on_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_pulse_o |-> !busy_o);

endmodule

// File: tb/divsync_ctrl_tb.sv
`timescale 1ns/1ps
module divsync_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int QW         = 8;
  localparam int BIG        = 1000000;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    int    cyc;
    int    kind;   // 0 divided clock, 1 sync pulse, 2 busy
    int    ch;
    logic  val;
    string req;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst;
  logic              src_sel, edge_sel, arm, dsync, fb_edge, ref_edge;
  logic [NCH*QW-1:0] ratio;
  logic [NCH-1:0]    mask;
  logic [NCH-1:0]    div_clk;
  logic              sync_pulse, busy;

  int       cyc = 0;
  int       checks = 0;
  int       errors = 0;
  bit       done = 0;
  sb_item_t sb[$];
  sb_item_t it;
  int       qv[NCH] = '{2, 3, 5, 4};
  int       c_r, rel_base;
  bit       ran = 0;

  divsync_ctrl #(.NCH(NCH), .QW(QW), .REL_DEPTH(3)) dut_i (
    .clk_i(clk), .rst_i(rst), .src_sel_i(src_sel), .edge_sel_i(edge_sel),
    .arm_i(arm), .dsync_i(dsync), .fb_edge_i(fb_edge), .ref_edge_i(ref_edge),
    .ratio_i(ratio), .mask_i(mask), .div_clk_o(div_clk),
    .sync_pulse_o(sync_pulse), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, got, exp);
    end
  endtask

  function automatic logic pat(int n, int base, int q);
    return ((n - base) % q) >= (q / 2);
  endfunction

  // R13 running shape, R3 frozen, R8 restart
  function automatic logic exp_unm(int n, int q, int s, int e);
    if (n >= e + 4) return pat(n, e + 4, q);
    if (n >= s)     return ran ? pat(s, rel_base, q) : 1'b0;
    return ran ? pat(n, rel_base, q) : 1'b0;
  endfunction

  task automatic push(int n, int kind, int ch, logic v, string req);
    sb_item_t x;
    x.cyc = n; x.kind = kind; x.ch = ch; x.val = v; x.req = req;
    sb.push_back(x);
  endtask

  task automatic push_window(int from, int to, int s, int e, string ctx);
    for (int n = from; n <= to; n++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (ch == 2)
          push(n, 0, ch, pat(n, c_r, qv[2]), {"R2 ", ctx});
        else
          push(n, 0, ch, exp_unm(n, qv[ch], s, e),
               (n >= e + 4) ? {"R8 ", ctx} : (n >= s) ? {"R3 ", ctx} : {"R13 ", ctx});
      end
      push(n, 1, 0, (n == e + 4), {"R9 ", ctx});
      push(n, 2, 0, (n >= s && n < e + 4), {"R10 ", ctx});
    end
  endtask

  task automatic wait_done();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic commit(int e);
    rel_base = e + 4;
    ran = 1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        it = sb.pop_front();
        if (it.cyc < cyc) chk({"stale ", it.req}, 1'b0, 1'b1);
        else if (it.kind == 0) chk({it.req, $sformatf(" ch%0d", it.ch)}, div_clk[it.ch], it.val);
        else if (it.kind == 1) chk(it.req, sync_pulse, it.val);
        else                   chk(it.req, busy, it.val);
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int c, e, s;
    rst = 1; src_sel = 0; edge_sel = 0; arm = 0; dsync = 0; fb_edge = 0; ref_edge = 0;
    mask = 4'b0100;
    for (int ch = 0; ch < NCH; ch++) ratio[ch*QW +: QW] = QW'(qv[ch]);
    repeat (3) @(negedge clk);
    rst = 0;
    c_r = cyc;
    // R1 reset state
    chk("R1 outputs low", |div_clk, 1'b0);
    chk("R1 sync pulse", sync_pulse, 1'b0);
    chk("R1 busy", busy, 1'b1);

    // R4 edges ignored in direct mode, R6 arm ignored in direct mode
    push_window(c_r + 1, c_r + 10, c_r, BIG, "R4 R6 idle");
    @(negedge clk); fb_edge = 1; @(negedge clk); fb_edge = 0;
    arm = 1; @(negedge clk); arm = 0; ref_edge = 1; @(negedge clk); ref_edge = 0;
    wait_done();

    // R4 direct request from the reset stall
    @(negedge clk); c = cyc; e = c + 1;
    dsync = 1;
    push_window(c + 1, e + 16, c_r, e, "R4 direct");
    @(negedge clk); dsync = 0;
    wait_done(); commit(e);

    // R4 direct request ignored in edge mode, R6 unarmed edge ignored
    @(negedge clk); c = cyc;
    src_sel = 1; edge_sel = 0;
    push_window(c + 1, c + 12, BIG, BIG, "R4 R6 edge mode");
    repeat (2) @(negedge clk); dsync = 1; @(negedge clk); dsync = 0;
    @(negedge clk); fb_edge = 1; @(negedge clk); fb_edge = 0;
    wait_done();

    // R5 feedback edge selected, reference ignored; R7 disarm after fire
    @(negedge clk); c = cyc; s = c + 2; e = c + 5;
    arm = 1;
    push_window(c + 1, e + 18, s, e, "R5 R7 feedback");
    @(negedge clk); arm = 0;
    @(negedge clk); ref_edge = 1;
    @(negedge clk); ref_edge = 0;
    @(negedge clk); fb_edge = 1;
    @(negedge clk); fb_edge = 0;
    repeat (9) @(negedge clk); fb_edge = 1;
    @(negedge clk); fb_edge = 0;
    wait_done(); commit(e);

    // R5 reference edge selected, feedback ignored
    @(negedge clk); c = cyc; s = c + 2; e = c + 5;
    edge_sel = 1; arm = 1;
    push_window(c + 1, e + 14, s, e, "R5 reference");
    @(negedge clk); arm = 0;
    @(negedge clk); fb_edge = 1;
    @(negedge clk); fb_edge = 0;
    @(negedge clk); ref_edge = 1;
    @(negedge clk); ref_edge = 0;
    wait_done(); commit(e);

    // R12 second request while a release is pending
    @(negedge clk); c = cyc; e = c + 1;
    src_sel = 0; dsync = 1;
    push_window(c + 1, e + 14, e + 1, e, "R12 pending");
    @(negedge clk);
    @(negedge clk); dsync = 0;
    wait_done(); commit(e);

    // R11 ratio 1 passes the clock, gated by the stall
    @(negedge clk); ratio[3*QW +: QW] = QW'(1);
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R11 high phase running", div_clk[3], 1'b1);
    @(negedge clk); #1;
    chk("R11 low phase running", div_clk[3], 1'b0);
    src_sel = 1; arm = 1;
    @(negedge clk); arm = 0;
    repeat (3) @(negedge clk);
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R11 gated while stalled", div_clk[3], 1'b0);
    chk("R10 busy after arm", busy, 1'b1);
    @(negedge clk); src_sel = 0; dsync = 1;
    @(negedge clk); dsync = 0;
    repeat (8) @(negedge clk);
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R11 passes after release", div_clk[3], 1'b1);
    chk("R10 busy cleared", busy, 1'b0);

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule